// File: doc/BRIEF.md
# Return Address Stack Controller

This block keeps a hardware stack of predicted return addresses for a RISC-V style core. Each cycle it may receive one resolved control transfer. The transfer carries a kind field, a destination register specifier, a source register specifier, the instruction PC and a size bit. The block sorts the transfer into a class code, and the class code tells it what to do to the stack. It can push the return address, pop the top entry, replace the top entry (pop and push in one cycle), or leave the stack alone.

A link register is one whose specifier is 1 or 5, and the stack action depends only on where link registers appear. All outputs are registered. The class code, the popped address with its valid flag, and the overflow and underflow pulses all appear one clock edge after the transfer is presented. Storage is a circular buffer that keeps the newest entries. When the buffer is full, the oldest entry is overwritten.

Top module: `ras_ctrl`

## Requirements
- R1: A register specifier (6 bits) counts as a link register only when it equals 1 or 5. Specifier 0 is the zero register. A specifier whose low bits match a link value but whose upper bit is set, such as 33, is not a link register.
- R2: For kind 3 (jalr), the class code and action are chosen as follows. If rd is a link register and rs is either not a link register or is the same link register, the code is 8 and the address is pushed. If rd and rs are two different link registers, the code is 12 and the top entry is swapped. If rd is not a link register and rs is a link register, the code is 13 and the top entry is popped. If rd is 0 and rs is not a link register, the code is 10 and there is no action. In every remaining case the code is 14 and there is no action.
- R3: For kind 2 (jal), an rd that is a link register gives code 9 and a push. An rd of 0 gives code 11 and no action. Any other rd gives code 15 and no action.
- R4: Kind 1 (branch) gives code 4. Kind 0 gives code 0. When in_valid is low the code is 0. None of these three cases changes the stack.
- R5: The pushed return address is PC+2 when the size bit is 0 (16-bit instruction) and PC+4 when the size bit is 1 (32-bit instruction).
- R6: A pop from a non-empty stack outputs the most recently pushed address that is still held, with pop_valid set to 1.
- R7: A pop from an empty stack outputs address 0 with pop_valid set to 0, and raises underflow for one cycle.
- R8: The stack holds DEPTH entries (default 16). A push when the stack is full overwrites the oldest entry, keeps the depth at DEPTH, and raises overflow for one cycle.
- R9: A swap on a non-empty stack outputs the old top entry with pop_valid set to 1 and writes the new return address in its place, so the depth does not change. A swap on an empty stack raises underflow, outputs 0 with pop_valid set to 0, and then pushes the new address.
- R10: All outputs change one clock edge after their input is sampled. While rst is high the stack is emptied and every output is 0. pop_valid, overflow and underflow are 0 in every cycle that follows an idle input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A transfer is present this cycle |
| in_kind | input | 2 | 0 other, 1 branch, 2 jal, 3 jalr |
| in_rd | input | REG_W | Destination register specifier |
| in_rs | input | REG_W | Source register specifier |
| in_pc | input | ADDR_W | Instruction PC |
| in_size | input | 1 | 0 = 16-bit instruction, 1 = 32-bit instruction |
| cls_code | output | 4 | Class code of the previous cycle's transfer |
| pop_addr | output | ADDR_W | Predicted return address (0 when not valid) |
| pop_valid | output | 1 | pop_addr holds a popped entry |
| overflow | output | 1 | A push overwrote the oldest entry |
| underflow | output | 1 | A pop found the stack empty |

## Verification
On every cycle, the assertions check the following:
- the occupancy never goes past DEPTH;
- overflow only happens when the stack was already full;
- underflow always comes with a zero, invalid output;
- a non-empty swap leaves the depth unchanged;
- every push or swap comes from a transfer whose rd is a link register;
- overflow and underflow are never raised together.

Other properties need the bench's reference model, which follows the stack contents through random and directed sequences. These include the exact class code for each combination of rd and rs, the PC+2 and PC+4 arithmetic, LIFO order, and the fact that the oldest entry is the one lost on overflow.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_PUSH = 2'd1,
    ACT_POP  = 2'd2,
    ACT_SWAP = 2'd3
  } ras_act_e;

  localparam logic [1:0] KIND_BRANCH = 2'd1;
  localparam logic [1:0] KIND_JAL    = 2'd2;
  localparam logic [1:0] KIND_JALR   = 2'd3;

  localparam logic [3:0] CODE_NONE      = 4'd0;
  localparam logic [3:0] CODE_BRANCH    = 4'd4;
  localparam logic [3:0] CODE_IND_CALL  = 4'd8;
  localparam logic [3:0] CODE_DIR_CALL  = 4'd9;
  localparam logic [3:0] CODE_IND_TAIL  = 4'd10;
  localparam logic [3:0] CODE_DIR_TAIL  = 4'd11;
  localparam logic [3:0] CODE_SWAP      = 4'd12;
  localparam logic [3:0] CODE_RETURN    = 4'd13;
  localparam logic [3:0] CODE_IND_OTHER = 4'd14;
  localparam logic [3:0] CODE_DIR_OTHER = 4'd15;
endpackage

// File: rtl/ras_classify.sv
module ras_classify
  import ras_pkg::*;
#(
  parameter int REG_W = 6
) (
  input  logic             valid,
  input  logic [1:0]       kind,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rs,
  output logic [3:0]       code,
  output ras_act_e         act
);
  localparam logic [REG_W-1:0] LINK_A = REG_W'(1);
  localparam logic [REG_W-1:0] LINK_B = REG_W'(5);
  localparam logic [REG_W-1:0] ZERO_R = '0;

  logic rd_link, rs_link, rd_zero, same_reg;

  always_comb begin
    rd_link  = (rd == LINK_A) || (rd == LINK_B);
    rs_link  = (rs == LINK_A) || (rs == LINK_B);
    rd_zero  = (rd == ZERO_R);
    same_reg = (rd == rs);
    code     = CODE_NONE;
    act      = ACT_NONE;
    if (valid) begin
      unique case (kind)
        KIND_BRANCH: code = CODE_BRANCH;
        KIND_JAL: begin
          if (rd_link) begin
            code = CODE_DIR_CALL;
            act  = ACT_PUSH;
          end else if (rd_zero) begin
            code = CODE_DIR_TAIL;
          end else begin
            code = CODE_DIR_OTHER;
          end
        end
        KIND_JALR: begin
          if (rd_link && rs_link && !same_reg) begin
            code = CODE_SWAP;
            act  = ACT_SWAP;
          end else if (rd_link) begin
            code = CODE_IND_CALL;
            act  = ACT_PUSH;
          end else if (rs_link) begin
            code = CODE_RETURN;
            act  = ACT_POP;
          end else if (rd_zero) begin
            code = CODE_IND_TAIL;
          end else begin
            code = CODE_IND_OTHER;
          end
        end
        default: code = CODE_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ras_stack.sv
module ras_stack
  import ras_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ras_act_e          act,
  input  logic [ADDR_W-1:0] push_data,
  output logic [ADDR_W-1:0] pop_data,
  output logic              pop_valid,
  output logic              overflow,
  output logic              underflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rd_q;
  logic [PW-1:0]     tos, tos_inc, tos_dec, wr_idx;
  logic [CW-1:0]     cnt;
  logic              empty, full, wr_en;

  always_comb begin
    empty   = (cnt == '0);
    full    = (cnt == FULL_CNT);
    tos_inc = (tos == LAST_IDX) ? '0 : tos + PW'(1);
    tos_dec = (tos == '0) ? LAST_IDX : tos - PW'(1);
    wr_en   = (act == ACT_PUSH) || (act == ACT_SWAP);
    wr_idx  = (act == ACT_SWAP && !empty) ? tos : tos_inc;
  end

  // Storage: one write port, one registered read port (read-first)
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[tos];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tos       <= '0;
      cnt       <= '0;
      pop_valid <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      pop_valid <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      unique case (act)
        ACT_PUSH: begin
          tos      <= tos_inc;
          overflow <= full;
          if (!full) cnt <= cnt + CW'(1);
        end
        ACT_POP: begin
          if (empty) begin
            underflow <= 1'b1;
          end else begin
            tos       <= tos_dec;
            cnt       <= cnt - CW'(1);
            pop_valid <= 1'b1;
          end
        end
        ACT_SWAP: begin
          if (empty) begin
            underflow <= 1'b1;
            tos       <= tos_inc;
            cnt       <= CW'(1);
          end else begin
            pop_valid <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign pop_data = pop_valid ? rd_q : '0;

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($past(cnt) == FULL_CNT) && (cnt == FULL_CNT));
  p_underflow_zero_r7: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (!pop_valid && pop_data == '0));
  p_swap_depth_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(act) == ACT_SWAP && $past(cnt) != '0) |-> (cnt == $past(cnt)));
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({overflow, underflow, pop_valid && underflow}));
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [REG_W-1:0]  in_rd,
  input  logic [REG_W-1:0]  in_rs,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic              in_size,
  output logic [3:0]        cls_code,
  output logic [ADDR_W-1:0] pop_addr,
  output logic              pop_valid,
  output logic              overflow,
  output logic              underflow
);
  logic [3:0]        code_c;
  ras_act_e          act_c;
  logic [ADDR_W-1:0] ret_addr;

  ras_classify #(.REG_W(REG_W)) u_classify (
    .valid (in_valid),
    .kind  (in_kind),
    .rd    (in_rd),
    .rs    (in_rs),
    .code  (code_c),
    .act   (act_c)
  );

  assign ret_addr = in_pc + (in_size ? ADDR_W'(4) : ADDR_W'(2));

  ras_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .act       (act_c),
    .push_data (ret_addr),
    .pop_data  (pop_addr),
    .pop_valid (pop_valid),
    .overflow  (overflow),
    .underflow (underflow)
  );

  always_ff @(posedge clk) begin
    if (rst) cls_code <= '0;
    else     cls_code <= code_c;
  end

  p_push_link_r2: assert property (@(posedge clk) disable iff (rst)
    (act_c == ACT_PUSH || act_c == ACT_SWAP) |->
      (in_rd == REG_W'(1) || in_rd == REG_W'(5)));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!pop_valid && !overflow && !underflow && cls_code == 4'd0));
endmodule

// File: tb/test_ras_ctrl.sv
module test_ras_ctrl;
  localparam int DEPTH = 16;
  localparam int AW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_size = 1'b0;
  logic [1:0] in_kind = '0;
  logic [5:0] in_rd = '0, in_rs = '0;
  logic [AW-1:0] in_pc = '0;
  logic [3:0] cls_code;
  logic [AW-1:0] pop_addr;
  logic pop_valid, overflow, underflow;

  int total = 0, bad = 0;
  logic [AW-1:0] q[$];

  always #4 clk = ~clk;

  ras_ctrl #(.DEPTH(DEPTH), .ADDR_W(AW), .REG_W(6)) i_ras_ctrl (
    .clk, .rst, .in_valid, .in_kind, .in_rd, .in_rs, .in_pc, .in_size,
    .cls_code, .pop_addr, .pop_valid, .overflow, .underflow
  );

  function automatic bit lnk(logic [5:0] r);
    return r == 6'd1 || r == 6'd5;
  endfunction

  function automatic logic [3:0] m_code(logic v, logic [1:0] k, logic [5:0] rd, logic [5:0] rs);
    if (!v) return 4'd0;
    case (k)
      2'd1: return 4'd4;
      2'd2: return lnk(rd) ? 4'd9 : (rd == 0 ? 4'd11 : 4'd15);
      2'd3: begin
        if (lnk(rd)) return (lnk(rs) && rs != rd) ? 4'd12 : 4'd8;
        if (lnk(rs)) return 4'd13;
        return rd == 0 ? 4'd10 : 4'd14;
      end
      default: return 4'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive at a negedge, advance one cycle, compare at the next negedge.
  task automatic step(string tag, logic v, logic [1:0] k, logic [5:0] rd,
                      logic [5:0] rs, logic [AW-1:0] pc, logic sz);
    logic [3:0] c;
    logic [AW-1:0] ra, e_addr;
    logic e_pv, e_ov, e_uf;
    string t, tc;
    c = m_code(v, k, rd, rs);
    ra = pc + (sz ? 32'd4 : 32'd2);
    e_addr = '0; e_pv = 0; e_ov = 0; e_uf = 0;
    t = "R4";
    case (c)
      4'd8, 4'd9: begin
        t = "R8";
        if (q.size() == DEPTH) begin void'(q.pop_front()); e_ov = 1; end
        q.push_back(ra);
      end
      4'd13: begin
        t = "R6";
        if (q.size() == 0) begin e_uf = 1; t = "R7"; end
        else begin e_addr = q.pop_back(); e_pv = 1; end
      end
      4'd12: begin
        t = "R9";
        if (q.size() == 0) begin e_uf = 1; q.push_back(ra); end
        else begin e_addr = q[$]; e_pv = 1; q[$] = ra; end
      end
      default: if (!v) t = "R10";
    endcase
    tc = (v && k == 2'd3) ? "R2" : (v && k == 2'd2) ? "R3" : "R4";
    if (tag != "") begin t = tag; tc = tag; end
    in_valid = v; in_kind = k; in_rd = rd; in_rs = rs; in_pc = pc; in_size = sz;
    @(negedge clk);
    chk(tc, cls_code, c, "cls_code");
    chk(t, pop_addr, e_addr, "pop_addr");
    chk(t, pop_valid, e_pv, "pop_valid");
    chk(t, overflow, e_ov, "overflow");
    chk(t, underflow, e_uf, "underflow");
  endtask

  function automatic logic [5:0] pick_reg();
    case ($urandom % 4)
      0: return 6'd0;
      1: return 6'd1;
      2: return 6'd5;
      default: return 6'($urandom % 64);
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10", {cls_code, pop_addr, pop_valid, overflow, underflow}, '0, "reset outputs");
    rst = 0;
    step("R10", 0, 2'd3, 6'd0, 6'd1, 32'h0, 1);
    // R7: pop on empty
    step("R7", 1, 2'd3, 6'd0, 6'd1, 32'h100, 1);
    // R1: 33 and 37 are not link registers
    step("R1", 1, 2'd2, 6'd33, 6'd0, 32'h200, 1);
    step("R1", 1, 2'd3, 6'd7, 6'd37, 32'h204, 1);
    // R5: size 0 pushes PC+2, size 1 pushes PC+4
    step("R5", 1, 2'd2, 6'd1, 6'd0, 32'h1000, 0);
    step("R5", 1, 2'd3, 6'd5, 6'd7, 32'h2000, 1);
    step("R5", 1, 2'd3, 6'd9, 6'd5, 32'h0, 1);
    step("R5", 1, 2'd3, 6'd9, 6'd1, 32'h0, 1);
    // R9: swap on empty, then swap on non-empty
    step("R9", 1, 2'd3, 6'd1, 6'd5, 32'h3000, 1);
    step("R9", 1, 2'd3, 6'd5, 6'd1, 32'h4000, 0);
    step("R9", 1, 2'd3, 6'd0, 6'd1, 32'h0, 1);
    step("R7", 1, 2'd3, 6'd0, 6'd5, 32'h0, 1);
    // R8: fill past capacity, then drain past empty
    for (int i = 0; i < DEPTH + 2; i++)
      step("R8", 1, 2'd2, 6'd1, 6'd0, 32'h8000 + 32'(i * 16), 1);
    for (int i = 0; i < DEPTH + 1; i++)
      step("R6", 1, 2'd3, 6'd0, 6'd1, 32'h0, 1);
    // R2 R3 R4: every rd/rs combination from a small set
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          logic [5:0] regs [4];
          regs[0] = 6'd0; regs[1] = 6'd1; regs[2] = 6'd5; regs[3] = 6'd9;
          step("", 1, 2'(k), regs[a], regs[b], 32'h5000 + 32'(k * 64 + a * 8 + b * 2), 1'(b));
        end
    // Random mix, idle cycles included
    for (int n = 0; n < 3000; n++)
      step("", ($urandom % 8) != 0, 2'($urandom % 4), pick_reg(), pick_reg(),
           ($urandom & 32'hFFFF_FFFE), 1'($urandom % 2));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule